// File: doc/BRIEF.md
# Shift Rotate and Swap Unit

This block takes one 8-bit operand per transaction and returns it after a one-place shift, a one-place rotate through the carry flag, or an exchange of its two nibbles. With the result it returns a new condition-flag vector and a write mask saying which flags the caller should commit. The caller supplies the current carry flag with each operand. Register-file access and instruction decoding belong to the surrounding logic.

Operands arrive on a valid/ready stream and results leave on a second valid/ready stream through one output register. An operand is accepted on a rising edge where `in_valid` and `in_ready` are both high. Its result is presented on `out_valid` from the next cycle onward. The result stays there, unchanged, until a rising edge where `out_ready` is high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle, so a result can be consumed and a new operand accepted on the same edge. When the consumer holds `out_ready` low, the unit stalls and drops nothing.

Operation codes on `in_op` are 0 = shift left, 1 = shift right, 2 = rotate left through carry, 3 = rotate right through carry, 4 = arithmetic shift right, 5 = nibble swap, and 6 and 7 are reserved. Flag vector bit positions, used by both `out_flags` and `out_wmask`, are: bit 0 carry C, bit 1 zero Z, bit 2 negative N, bit 3 overflow V, bit 4 sign S.

Top module: `ssu_top`

## Requirements
- R1: Op 0 (shift left) gives result = operand shifted up one place with bit 0 = 0, and C = old bit 7.
- R2: Op 1 (shift right) gives result = operand shifted down one place with bit 7 = 0, and C = old bit 0.
- R3: Op 2 (rotate left) gives result bits 7..1 = old bits 6..0, bit 0 = incoming carry, and C = old bit 7.
- R4: Op 3 (rotate right) gives result bits 6..0 = old bits 7..1, bit 7 = incoming carry, and C = old bit 0.
- R5: Op 4 (arithmetic shift right) gives result bits 6..0 = old bits 7..1, bit 7 = old bit 7, and C = old bit 0.
- R6: Op 5 (swap) gives result bits 3..0 = old bits 7..4 and bits 7..4 = old bits 3..0, with `out_flags` = 0 and `out_wmask` = 0.
- R7: For ops 0 to 4, N (flag bit 2) equals result bit 7, and Z (flag bit 1) is 1 exactly when the result is zero.
- R8: For ops 0 to 4, V (flag bit 3) = N xor C and S (flag bit 4) = N xor V.
- R9: For ops 0 to 4, `out_wmask` = 5'h1F.
- R10: Reserved ops 6 and 7 return the operand unchanged, with `out_flags` = 0 and `out_wmask` = 0.
- R11: The result of an operand accepted at a rising edge is valid on the outputs immediately after that edge.
- R12: While `out_valid` is high and `out_ready` is low, `in_ready` is low and the result, flags and mask hold steady.
- R13: During and immediately after reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand stream valid |
| in_ready | output | 1 | Operand stream ready |
| in_op | input | 3 | Operation code |
| in_operand | input | 8 | Operand value |
| in_carry | input | 1 | Current carry flag |
| out_valid | output | 1 | Result stream valid |
| out_ready | input | 1 | Result stream ready |
| out_result | output | 8 | Result value |
| out_flags | output | 5 | New flag values {S,V,N,Z,C} |
| out_wmask | output | 5 | Per-flag write enable, same bit order |

## Verification
The only state is the output register and its valid bit, so a wrong internal value appears at the ports one cycle after the operand is accepted. A wrong valid bit shows up first as an incorrect `in_ready`, in the same cycle it occurs. A corrupted held result during a stall changes the outputs on the very next edge. The bench therefore samples every transaction at the first output cycle, and it checks the held values across several stalled cycles.

// File: rtl/ssu_pkg.sv
package ssu_pkg;
  localparam int unsigned OP_W   = 3;
  localparam int unsigned FLAG_W = 5;

  localparam logic [OP_W-1:0] OP_SHL  = 3'd0;
  localparam logic [OP_W-1:0] OP_SHR  = 3'd1;
  localparam logic [OP_W-1:0] OP_RCL  = 3'd2;
  localparam logic [OP_W-1:0] OP_RCR  = 3'd3;
  localparam logic [OP_W-1:0] OP_SAR  = 3'd4;
  localparam logic [OP_W-1:0] OP_NSWP = 3'd5;

  localparam int unsigned FLG_C = 0;
  localparam int unsigned FLG_Z = 1;
  localparam int unsigned FLG_N = 2;
  localparam int unsigned FLG_V = 3;
  localparam int unsigned FLG_S = 4;
endpackage

// File: rtl/ssu_shifter.sv
module ssu_shifter
  import ssu_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [OP_W-1:0]  op,
  input  logic [WIDTH-1:0] a,
  input  logic             cin,
  output logic [WIDTH-1:0] res,
  output logic             cout,
  output logic             is_shift
);
  localparam int unsigned HALF = WIDTH / 2;
  localparam int unsigned MSB  = WIDTH - 1;

  logic [WIDTH-1:0] swapped;

  generate
    if (WIDTH % 2 == 0) begin : g_even
      assign swapped = {a[HALF-1:0], a[WIDTH-1:HALF]};
    end else begin : g_odd
      assign swapped = a;
    end
  endgenerate

  always_comb begin
    res      = a;
    cout     = 1'b0;
    is_shift = 1'b1;
    case (op)
      OP_SHL: begin res = {a[MSB-1:0], 1'b0}; cout = a[MSB]; end
      OP_SHR: begin res = {1'b0, a[MSB:1]};   cout = a[0];   end
      OP_RCL: begin res = {a[MSB-1:0], cin};  cout = a[MSB]; end
      OP_RCR: begin res = {cin, a[MSB:1]};    cout = a[0];   end
      OP_SAR: begin res = {a[MSB], a[MSB:1]}; cout = a[0];   end
      OP_NSWP: begin res = swapped; is_shift = 1'b0; end
      default: begin res = a; is_shift = 1'b0; end
    endcase
  end
endmodule

// File: rtl/ssu_flags.sv
module ssu_flags
  import ssu_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0]  res,
  input  logic              cout,
  input  logic              is_shift,
  output logic [FLAG_W-1:0] flags,
  output logic [FLAG_W-1:0] wmask
);
  logic neg, zero, ovf, sgn;

  assign neg  = res[WIDTH-1];
  assign zero = ~|res;
  assign ovf  = neg ^ cout;
  assign sgn  = neg ^ ovf;

  always_comb begin
    flags = '0;
    wmask = '0;
    if (is_shift) begin
      flags[FLG_C] = cout;
      flags[FLG_Z] = zero;
      flags[FLG_N] = neg;
      flags[FLG_V] = ovf;
      flags[FLG_S] = sgn;
      wmask        = '1;
    end
  end
endmodule

// File: rtl/ssu_outreg.sv
module ssu_outreg #(
  parameter int unsigned DW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [DW-1:0] s_data,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [DW-1:0] m_data
);
  assign s_ready = !m_valid || m_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= '0;
    end else if (s_ready) begin
      m_valid <= s_valid;
      if (s_valid) m_data <= s_data;
    end
  end

  a_r12_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_data));
  a_r12_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |-> !s_ready);
  a_r11_accept: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid && s_ready |=> m_valid && m_data == $past(s_data));
endmodule

// File: rtl/ssu_top.sv
module ssu_top
  import ssu_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OP_W-1:0]   in_op,
  input  logic [WIDTH-1:0]  in_operand,
  input  logic              in_carry,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WIDTH-1:0]  out_result,
  output logic [FLAG_W-1:0] out_flags,
  output logic [FLAG_W-1:0] out_wmask
);
  localparam int unsigned PKT_W = WIDTH + 2 * FLAG_W;

  logic [WIDTH-1:0]  sh_res;
  logic              sh_cout;
  logic              sh_is_shift;
  logic [FLAG_W-1:0] fl_flags;
  logic [FLAG_W-1:0] fl_wmask;
  logic [PKT_W-1:0]  pkt_in, pkt_out;

  ssu_shifter #(.WIDTH(WIDTH)) u_shifter (
    .op(in_op), .a(in_operand), .cin(in_carry),
    .res(sh_res), .cout(sh_cout), .is_shift(sh_is_shift)
  );

  ssu_flags #(.WIDTH(WIDTH)) u_flags (
    .res(sh_res), .cout(sh_cout), .is_shift(sh_is_shift),
    .flags(fl_flags), .wmask(fl_wmask)
  );

  assign pkt_in = {fl_wmask, fl_flags, sh_res};

  ssu_outreg #(.DW(PKT_W)) u_outreg (
    .clk(clk), .rst_n(rst_n),
    .s_valid(in_valid), .s_ready(in_ready), .s_data(pkt_in),
    .m_valid(out_valid), .m_ready(out_ready), .m_data(pkt_out)
  );

  assign out_result = pkt_out[WIDTH-1:0];
  assign out_flags  = pkt_out[WIDTH +: FLAG_W];
  assign out_wmask  = pkt_out[WIDTH+FLAG_W +: FLAG_W];

  a_r7_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_wmask[FLG_Z] |-> out_flags[FLG_Z] == (out_result == '0));
  a_r7_neg: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_wmask[FLG_N] |-> out_flags[FLG_N] == out_result[WIDTH-1]);
  a_r8_sign: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_wmask[FLG_S] |-> out_flags[FLG_S] == (out_flags[FLG_N] ^ out_flags[FLG_V]));
  a_r9_mask_shape: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_wmask == '0 || out_wmask == '1));
  a_r6_swap_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_op == OP_NSWP |=> out_wmask == '0 && out_flags == '0);
  a_r1_shl: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_op == OP_SHL |=>
      out_result == {$past(in_operand[WIDTH-2:0]), 1'b0});
endmodule

// File: tb/tb_ssu_top.sv
module tb_ssu_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [2:0] in_op = '0;
  logic [7:0] in_operand = '0;
  logic       in_carry = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_result;
  logic [4:0] out_flags;
  logic [4:0] out_wmask;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  ssu_top dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_operand(in_operand), .in_carry(in_carry),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_flags(out_flags), .out_wmask(out_wmask)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pattern(input int i);
    case (i)
      0: return 8'h00; 1: return 8'h80; 2: return 8'h01; 3: return 8'hFF;
      4: return 8'hA5; 5: return 8'h5A; 6: return 8'h7F; default: return 8'h40;
    endcase
  endfunction

  function automatic string op_tag(input int op);
    case (op)
      0: return "R1"; 1: return "R2"; 2: return "R3"; 3: return "R4";
      4: return "R5"; 5: return "R6"; default: return "R10";
    endcase
  endfunction

  // Expected values from the requirement text; flags order {S,V,N,Z,C}
  task automatic model(input int op, input logic [7:0] a, input logic ci,
                       output logic [7:0] r, output logic [4:0] f, output logic [4:0] m);
    logic c, n, z, v, s;
    c = 1'b0;
    case (op)
      0: begin r = {a[6:0], 1'b0}; c = a[7]; end
      1: begin r = {1'b0, a[7:1]}; c = a[0]; end
      2: begin r = {a[6:0], ci};   c = a[7]; end
      3: begin r = {ci, a[7:1]};   c = a[0]; end
      4: begin r = {a[7], a[7:1]}; c = a[0]; end
      5: r = {a[3:0], a[7:4]};
      default: r = a;
    endcase
    n = r[7]; z = (r == 8'h00); v = n ^ c; s = n ^ v;
    if (op <= 4) begin f = {s, v, n, z, c}; m = 5'h1F; end
    else begin f = 5'h00; m = 5'h00; end
  endtask

  task automatic run_op(input int op, input logic [7:0] a, input logic ci);
    logic [7:0] er; logic [4:0] ef, em;
    model(op, a, ci, er, ef, em);
    @(negedge clk);
    in_valid = 1'b1; in_op = op[2:0]; in_operand = a; in_carry = ci;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R11 out_valid", {31'd0, out_valid}, 32'd1);
    chk(op_tag(op), {24'd0, out_result}, {24'd0, er});
    chk("R7 R8 flags", {27'd0, out_flags}, {27'd0, ef});
    chk("R9 mask", {27'd0, out_wmask}, {27'd0, em});
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R13 valid in reset", {31'd0, out_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R13 valid after reset", {31'd0, out_valid}, 32'd0);
    chk("R13 ready after reset", {31'd0, in_ready}, 32'd1);
  endtask

  task automatic test_shifts();
    for (int op = 0; op < 5; op++)
      for (int i = 0; i < 8; i++)
        for (int c = 0; c < 2; c++)
          run_op(op, pattern(i), c[0]);
  endtask

  task automatic test_swap();
    for (int i = 0; i < 8; i++) run_op(5, pattern(i), i[0]);
  endtask

  task automatic test_reserved();
    for (int i = 0; i < 8; i++) begin
      run_op(6, pattern(i), 1'b1);
      run_op(7, pattern(i), 1'b0);
    end
  endtask

  task automatic test_corners();
    // R7 R8: 0x80 shifted left gives zero result, C=1, V=1, S=1
    run_op(0, 8'h80, 1'b0);
    chk("R7 zero flag", {31'd0, out_flags[1]}, 32'd1);
    chk("R8 sign flag", {31'd0, out_flags[4]}, 32'd1);
    // R5: sign bit is kept on negative operand
    run_op(4, 8'h81, 1'b0);
    chk("R5 sign kept", {24'd0, out_result}, 32'hC0);
  endtask

  task automatic test_backpressure();
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_op = 3'd1; in_operand = 8'h3C; in_carry = 1'b0;
    @(negedge clk);
    in_op = 3'd5; in_operand = 8'h12;
    chk("R12 first valid", {31'd0, out_valid}, 32'd1);
    chk("R12 ready low", {31'd0, in_ready}, 32'd0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R12 held result", {24'd0, out_result}, 32'h1E);
      chk("R12 held flags", {27'd0, out_flags}, 32'h00);
      chk("R12 held mask", {27'd0, out_wmask}, 32'h1F);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R12 second result", {24'd0, out_result}, 32'h21);
    chk("R12 second mask", {27'd0, out_wmask}, 32'h00);
    @(negedge clk);
    chk("R12 drained", {31'd0, out_valid}, 32'd0);
  endtask

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    test_reset();
    test_shifts();
    test_swap();
    test_reserved();
    test_corners();
    test_backpressure();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule